// File: doc/BRIEF.md
# Compare Timer with Watchdog Reset

This block is a 16-bit up-counter fed by a power-of-two prescaler, with two compare channels. Each channel watches the counter in one of four modes (off, equal, greater-or-equal, event) and sets a sticky status flag when it hits. The flags drive per-channel interrupt lines through a mask. When a separate arm input is high, a hit on compare channel 2 raises a system-reset request, so the block can serve as a watchdog. Software kicks it by writing the counter back to zero before channel 2 is reached.

A host accesses four 16-bit registers on a simple write-strobe bus. These are compare value 1, compare value 2, the counter and a setup word. The setup word picks the prescale exponent, the tick source, both channel modes and the debug-stop option. It also holds the counter enable and the two status flags. The configuration fields of the setup word lock after the first write.

Top module: `cmt_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) every register reads 0, `irq` is 0 and `rst_req` is 0.
- R2: Register index is reg_addr[2:1]: 0 compare 1, 1 compare 2, 2 counter, 3 setup; reg_addr[0] is ignored. A write with reg_wr high takes effect at the clock edge, and reg_rdata shows the indexed register combinationally.
- R3: Setup layout: [3:0] prescale exponent D, [4] source, [7:6] mode 1, [9:8] mode 2, [11] stop enable, [12] locked, [13] flag 1, [14] flag 2, [15] counter enable; bits 5 and 10 read 0. With enable set, the counter advances by one on every 2^D-th base tick, and with enable clear it holds.
- R4: Source 0 makes every clock cycle a base tick; source 1 uses only cycles with ext_tick high.
- R5: Mode encoding: 00 off, 01 hit when counter equals the compare value, 10 hit when counter is greater or equal, 11 (event) hit on equality. A hit is seen only while the counter is running and sets its flag at the next edge; mode 00 never sets it.
- R6: With mode 2 set to event, a tick while the counter equals compare 2 reloads the counter with 0 instead of incrementing.
- R7: Flags are write-one-to-clear through setup bits 13/14; writing 0 leaves them; a hit in the same cycle as a clear wins.
- R8: The first setup write loads the configuration fields and sets the locked bit; later writes change only counter enable and clear flags.
- R9: A counter write loads the written value and restarts the prescaler, so writing 0 restarts the count.
- R10: With stop enable set, the counter, the prescaler and both comparators are frozen while dbg_halt is high.
- R11: irq[i] is high exactly when flag i+1 is set and irq_mask[i] is high.
- R12: A channel-2 hit while wdog_arm is high sets rst_req at the next edge, and it stays high until reset; with wdog_arm low no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| ext_tick | input | 1 | Alternate base tick, one-cycle pulses |
| dbg_halt | input | 1 | Debug halt request |
| irq_mask | input | 2 | Interrupt mask, one bit per channel |
| wdog_arm | input | 1 | Lets a channel-2 hit request a system reset |
| irq | output | 2 | Masked channel interrupts |
| rst_req | output | 1 | Sticky system-reset request |

## Verification
Directed runs pin down single behaviours with hand-computed values. One shows prescaling at divide-by-four, which tells a correct tick period from off-by-one periods. Others cover an idle external source, event-mode wraparound at a small compare-2 value, and the greater-or-equal flag surviving a clear in the same cycle. Further runs cover the frozen counter under halt, setup locking, and the reset request armed and unarmed. Random rounds then mix random modes, prescales, sources, halt pulses, masks and register writes against a cycle model. These catch interactions such as a counter write landing on a tick or a wrap landing on a compare hit.

// File: rtl/cmt_pkg.sv
// Shared types for the compare timer: register indices, channel modes and
// the lockable configuration fields of the setup word.
package cmt_pkg;
    localparam int DATA_W = 16;
    localparam int DIV_W  = 4;

    localparam logic [1:0] IDX_CMP1  = 2'd0;
    localparam logic [1:0] IDX_CMP2  = 2'd1;
    localparam logic [1:0] IDX_COUNT = 2'd2;
    localparam logic [1:0] IDX_SETUP = 2'd3;

    typedef enum logic [1:0] {
        CMP_OFF = 2'b00,
        CMP_EQ  = 2'b01,
        CMP_GE  = 2'b10,
        CMP_EVT = 2'b11
    } cmp_mode_e;

    typedef struct packed {
        logic             stop_en;
        cmp_mode_e        mode2;
        cmp_mode_e        mode1;
        logic             src;
        logic [DIV_W-1:0] div;
    } cfg_t;
endpackage

// File: rtl/cmt_regs.sv
// Register file of the compare timer. Holds both compare values, the
// lockable configuration, counter enable and the two sticky status flags.
// Assumes even byte offsets; the counter itself lives in cmt_counter, so a
// counter write is passed on as a load strobe and its value read back in.
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [1:0]   idx,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cnt,
    input  logic [1:0]   hit,
    output logic [W-1:0] cmp1,
    output logic [W-1:0] cmp2,
    output cfg_t         cfg,
    output logic         cnt_en,
    output logic [1:0]   flags,
    output logic         cnt_load,
    output logic [W-1:0] rdata
);
    logic locked;
    logic wr_setup;
    logic [1:0] clr;
    logic unused_bits;

    assign wr_setup    = wr && (idx == IDX_SETUP);
    assign cnt_load    = wr && (idx == IDX_COUNT);
    assign clr         = wr_setup ? wdata[14:13] : 2'b00;
    assign unused_bits = ^{wdata[12], wdata[10], wdata[5]};

    // Compare value registers, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp1 <= '0;
            cmp2 <= '0;
        end else if (wr && idx == IDX_CMP1) begin
            cmp1 <= wdata;
        end else if (wr && idx == IDX_CMP2) begin
            cmp2 <= wdata;
        end
    end

    // Setup word: configuration loads once, enable on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg    <= '0;
            locked <= 1'b0;
            cnt_en <= 1'b0;
        end else if (wr_setup) begin
            cnt_en <= wdata[15];
            if (!locked) begin
                cfg.stop_en <= wdata[11];
                cfg.mode2   <= cmp_mode_e'(wdata[9:8]);
                cfg.mode1   <= cmp_mode_e'(wdata[7:6]);
                cfg.src     <= wdata[4];
                cfg.div     <= wdata[3:0];
                locked      <= 1'b1;
            end
        end
    end

    // Sticky flags: a hit sets, a written one clears, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= 2'b00;
        else        flags <= (flags & ~clr) | hit;
    end

    // Combinational read mux.
    always_comb begin
        case (idx)
            IDX_CMP1:  rdata = cmp1;
            IDX_CMP2:  rdata = cmp2;
            IDX_COUNT: rdata = cnt;
            default:   rdata = {cnt_en, flags[1], flags[0], locked, cfg.stop_en, 1'b0,
                                cfg.mode2, cfg.mode1, 1'b0, cfg.src, cfg.div};
        endcase
    end

    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_setup) |=> $stable(cfg));

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !clr[0]) |=> flags[0]);

    p_flag_hold2_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[1] && !clr[1]) |=> flags[1]);
endmodule

// File: rtl/cmt_prescale.sv
// Power-of-two prescaler. Counts base ticks while running and emits a tick
// on every 2^div-th one. Assumes div never exceeds the prescaler width.
module cmt_prescale #(
    parameter int DIV_W = 4,
    localparam int PRE_W = (1 << DIV_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             base,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;

    assign mask = PRE_W'((32'd1 << div) - 32'd1);
    assign tick = run && base && ((pre & mask) == mask);

    // Base tick counter, restarted by a counter load.
    always_ff @(posedge clk) begin
        if (!rst_n)           pre <= '0;
        else if (clr)         pre <= '0;
        else if (run && base) pre <= pre + PRE_W'(1);
    end

    p_pre_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(pre));
endmodule

// File: rtl/cmt_counter.sv
// Main counter and the two comparators. Counts on prescaled ticks, loads on
// a host write and wraps at compare 2 in event mode. Channel hits are valid
// only while the counter runs.
module cmt_counter
    import cmt_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N_CH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] cmp1,
    input  logic [W-1:0] cmp2,
    input  cmp_mode_e    mode1,
    input  cmp_mode_e    mode2,
    output logic [W-1:0] cnt,
    output logic [N_CH-1:0] hit
);
    logic [W-1:0] ref_v  [N_CH];
    cmp_mode_e    mode_v [N_CH];
    logic         wrap;

    assign ref_v[0]  = cmp1;
    assign ref_v[1]  = cmp2;
    assign mode_v[0] = mode1;
    assign mode_v[1] = mode2;
    assign wrap      = (mode2 == CMP_EVT) && (cnt == cmp2);

    // One comparator per channel.
    for (genvar g = 0; g < N_CH; g++) begin : g_cmp
        always_comb begin
            case (mode_v[g])
                CMP_EQ, CMP_EVT: hit[g] = run && (cnt == ref_v[g]);
                CMP_GE:          hit[g] = run && (cnt >= ref_v[g]);
                default:         hit[g] = 1'b0;
            endcase
        end
    end

    // Counter: load beats tick, event mode wraps at compare 2.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= ld_val;
        else if (tick) cnt <= wrap ? '0 : cnt + W'(1);
    end

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !wrap) |=> (cnt == $past(cnt) + W'(1)));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && wrap) |=> (cnt == '0));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));

    p_no_hit_halted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (hit == '0));
endmodule

// File: rtl/cmt_timer.sv
// Top of the compare timer with watchdog reset. Selects the base tick,
// applies the debug stop, masks the flags onto irq and latches the reset
// request. Assumes ext_tick is synchronous to clk.
module cmt_timer
    import cmt_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic              ext_tick,
    input  logic              dbg_halt,
    input  logic [1:0]        irq_mask,
    input  logic              wdog_arm,
    output logic [1:0]        irq,
    output logic              rst_req
);
    cfg_t         cfg;
    logic [W-1:0] cmp1, cmp2, cnt;
    logic         cnt_en, cnt_load, run, base, tick;
    logic [1:0]   flags, hit;
    logic         unused_addr;

    assign unused_addr = reg_addr[0];
    assign run  = cnt_en && !(cfg.stop_en && dbg_halt);
    assign base = cfg.src ? ext_tick : 1'b1;
    assign irq  = flags & irq_mask;

    cmt_regs #(.W(W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_addr[2:1]),
        .wdata(reg_wdata), .cnt(cnt), .hit(hit), .cmp1(cmp1), .cmp2(cmp2),
        .cfg(cfg), .cnt_en(cnt_en), .flags(flags), .cnt_load(cnt_load),
        .rdata(reg_rdata)
    );

    cmt_prescale #(.DIV_W(DIV_W)) pre_i (
        .clk(clk), .rst_n(rst_n), .clr(cnt_load), .run(run), .base(base),
        .div(cfg.div), .tick(tick)
    );

    cmt_counter #(.W(W), .N_CH(2)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .ld_val(reg_wdata),
        .run(run), .tick(tick), .cmp1(cmp1), .cmp2(cmp2),
        .mode1(cfg.mode1), .mode2(cfg.mode2), .cnt(cnt), .hit(hit)
    );

    // Reset request: set by an armed channel-2 hit, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= rst_req | (wdog_arm & hit[1]);
    end

    p_req_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    p_req_unarmed_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && !wdog_arm) |=> !rst_req);
endmodule

// File: tb/cmt_timer_tb.sv
module cmt_timer_tb_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0, reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic        ext_tick = 1'b0, dbg_halt = 1'b0, wdog_arm = 1'b0;
    logic [1:0]  irq_mask = 2'b00;
    wire  [15:0] reg_rdata;
    wire  [1:0]  irq;
    wire         rst_req;

    cmt_timer dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_tick(ext_tick),
        .dbg_halt(dbg_halt), .irq_mask(irq_mask), .wdog_arm(wdog_arm),
        .irq(irq), .rst_req(rst_req)
    );

    int    checks = 0, errors = 0;
    string tag = "R1";

    // Reference model state, built from the requirements.
    logic [15:0] m_c1, m_c2, m_cnt;
    logic [14:0] m_pre;
    logic [3:0]  m_div;
    logic [1:0]  m_m1, m_m2, m_st;
    logic        m_src, m_stop, m_lock, m_en, m_req;

    function automatic logic m_hit(logic run, logic [1:0] md, logic [15:0] c, logic [15:0] r);
        case (md)
            2'b01, 2'b11: return run && (c == r);
            2'b10:        return run && (c >= r);
            default:      return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] m_read(logic [1:0] i);
        case (i)
            2'd0: return m_c1;
            2'd1: return m_c2;
            2'd2: return m_cnt;
            default: return {m_en, m_st[1], m_st[0], m_lock, m_stop, 1'b0, m_m2, m_m1, 1'b0, m_src, m_div};
        endcase
    endfunction

    function automatic logic [15:0] sw(logic en, logic [1:0] clr, logic stop, logic [1:0] m2,
                                       logic [1:0] m1, logic src, logic [3:0] dv);
        return {en, clr[1], clr[0], 1'b0, stop, 1'b0, m2, m1, 1'b0, src, dv};
    endfunction

    always @(posedge clk) begin : model
        logic run, base, tick, h1, h2;
        logic [14:0] msk;
        logic [1:0] clr;
        if (!rst_n) begin
            m_c1 = 0; m_c2 = 0; m_cnt = 0; m_pre = 0; m_div = 0; m_m1 = 0; m_m2 = 0;
            m_st = 0; m_src = 0; m_stop = 0; m_lock = 0; m_en = 0; m_req = 0;
        end else begin
            run  = m_en && !(m_stop && dbg_halt);
            base = m_src ? ext_tick : 1'b1;
            msk  = 15'((32'd1 << m_div) - 32'd1);
            tick = run && base && ((m_pre & msk) == msk);
            h1   = m_hit(run, m_m1, m_cnt, m_c1);
            h2   = m_hit(run, m_m2, m_cnt, m_c2);
            clr  = (reg_wr && reg_addr[2:1] == 2'd3) ? reg_wdata[14:13] : 2'b00;
            if (reg_wr && reg_addr[2:1] == 2'd2) begin
                m_cnt = reg_wdata; m_pre = 0;
            end else begin
                if (tick) m_cnt = (m_m2 == 2'b11 && m_cnt == m_c2) ? 16'd0 : m_cnt + 16'd1;
                if (run && base) m_pre = m_pre + 15'd1;
            end
            m_st  = (m_st & ~clr) | {h2, h1};
            m_req = m_req | (wdog_arm && h2);
            if (reg_wr && reg_addr[2:1] == 2'd3) begin
                m_en = reg_wdata[15];
                if (!m_lock) begin
                    m_stop = reg_wdata[11]; m_m2 = reg_wdata[9:8]; m_m1 = reg_wdata[7:6];
                    m_src = reg_wdata[4]; m_div = reg_wdata[3:0]; m_lock = 1'b1;
                end
            end
            if (reg_wr && reg_addr[2:1] == 2'd0) m_c1 = reg_wdata;
            if (reg_wr && reg_addr[2:1] == 2'd1) m_c2 = reg_wdata;
        end
    end

    task automatic chk(string t, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    // One cycle: compare outputs against the model, then drive new inputs.
    task automatic step(logic wr, logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        if (rst_n) begin
            chk({tag, " rdata"}, reg_rdata, m_read(reg_addr[2:1]));
            chk({tag, " irq R11"}, {14'd0, irq}, {14'd0, m_st & irq_mask});
            chk({tag, " rst_req R12"}, {15'd0, rst_req}, {15'd0, m_req});
        end
        reg_wr = wr; reg_addr = a; reg_wdata = d;
    endtask

    task automatic rd_exp(string t, logic [2:0] a, logic [15:0] exp);
        step(1'b0, a, 16'd0);
        @(posedge clk); #1;
        chk(t, reg_rdata, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ext_tick = 0; dbg_halt = 0; wdog_arm = 0; irq_mask = 0;
        step(1'b0, 3'd0, 16'd0);
        step(1'b0, 3'd0, 16'd0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd20240611);
        // R1: reset state
        tag = "R1";
        do_reset();
        for (int a = 0; a < 4; a++) rd_exp("R1 reg after reset", 3'(a * 2), 16'd0);
        chk("R1 irq", {14'd0, irq}, 16'd0);
        chk("R1 rst_req", {15'd0, rst_req}, 16'd0);

        // R2 / R9: addressing and counter load
        tag = "R2";
        step(1'b1, 3'd4, 16'h1234);
        rd_exp("R9 counter load", 3'd4, 16'h1234);
        step(1'b1, 3'd0, 16'hBEEF);
        rd_exp("R2 compare 1", 3'd0, 16'hBEEF);
        step(1'b1, 3'd3, 16'h00AA);
        rd_exp("R2 odd offset hits compare 2", 3'd2, 16'h00AA);

        // R8: first setup write locks configuration
        tag = "R8";
        step(1'b1, 3'd6, sw(1, 2'b00, 0, 2'b00, 2'b01, 0, 4'd2));
        rd_exp("R8 first setup", 3'd6, 16'h9042);
        step(1'b1, 3'd6, sw(0, 2'b00, 1, 2'b11, 2'b10, 1, 4'd5));
        rd_exp("R8 locked setup", 3'd6, 16'h1042);

        // R3: divide by four
        tag = "R3";
        do_reset();
        step(1'b1, 3'd6, sw(1, 2'b00, 0, 2'b00, 2'b00, 0, 4'd2));
        step(1'b1, 3'd4, 16'd0);
        repeat (39) step(1'b0, 3'd4, 16'd0);
        rd_exp("R3 count after 40 base ticks", 3'd4, 16'd10);

        // R4: external source with no pulses holds the count
        tag = "R4";
        do_reset();
        step(1'b1, 3'd6, sw(1, 2'b00, 0, 2'b00, 2'b00, 1, 4'd0));
        repeat (20) step(1'b0, 3'd4, 16'd0);
        rd_exp("R4 idle external source", 3'd4, 16'd0);
        for (int i = 0; i < 30; i++) begin
            ext_tick = (i % 3 == 0);
            step(1'b0, 3'd4, 16'd0);
        end
        ext_tick = 0;

        // R6: event mode wraps at compare 2
        tag = "R6";
        do_reset();
        step(1'b1, 3'd2, 16'd3);
        step(1'b1, 3'd6, sw(1, 2'b00, 0, 2'b11, 2'b00, 0, 4'd0));
        step(1'b1, 3'd4, 16'd0);
        repeat (19) step(1'b0, 3'd4, 16'd0);
        rd_exp("R6 wrapped count", 3'd4, 16'd0);

        // R5 / R7: greater-or-equal flag and write-one-to-clear
        tag = "R5";
        do_reset();
        irq_mask = 2'b01;
        step(1'b1, 3'd0, 16'd2);
        step(1'b1, 3'd6, sw(1, 2'b00, 0, 2'b00, 2'b10, 0, 4'd0));
        repeat (8) step(1'b0, 3'd6, 16'd0);
        tag = "R7";
        step(1'b1, 3'd6, sw(1, 2'b01, 0, 2'b00, 2'b00, 0, 4'd0));
        rd_exp("R7 set wins over clear", 3'd6, 16'hB080);
        step(1'b1, 3'd0, 16'hFFFF);
        step(1'b1, 3'd6, sw(1, 2'b01, 0, 2'b00, 2'b00, 0, 4'd0));
        rd_exp("R7 flag cleared", 3'd6, 16'h9080);

        // R10: debug stop freezes counter
        tag = "R10";
        do_reset();
        step(1'b1, 3'd6, sw(1, 2'b00, 1, 2'b00, 2'b00, 0, 4'd0));
        step(1'b1, 3'd4, 16'd100);
        dbg_halt = 1;
        repeat (10) step(1'b0, 3'd4, 16'd0);
        rd_exp("R10 halted count", 3'd4, 16'd100);
        dbg_halt = 0;
        repeat (5) step(1'b0, 3'd4, 16'd0);

        // R12: armed and unarmed watchdog
        tag = "R12";
        do_reset();
        step(1'b1, 3'd2, 16'd5);
        step(1'b1, 3'd6, sw(1, 2'b00, 0, 2'b01, 2'b00, 0, 4'd0));
        repeat (12) step(1'b0, 3'd4, 16'd0);
        rd_exp("R12 unarmed keeps request low", 3'd6, 16'hD100);
        chk("R12 unarmed rst_req", {15'd0, rst_req}, 16'd0);
        wdog_arm = 1;
        step(1'b1, 3'd4, 16'd0);
        repeat (8) step(1'b0, 3'd4, 16'd0);
        wdog_arm = 0;
        repeat (4) step(1'b0, 3'd4, 16'd0);
        chk("R12 request held", {15'd0, rst_req}, 16'd1);
        do_reset();
        step(1'b0, 3'd0, 16'd0);
        chk("R12 request cleared by reset", {15'd0, rst_req}, 16'd0);

        // Random rounds covering R3 R4 R5 R6 R7 R10 R11 R12 against the model
        tag = "R5 R11 random";
        for (int r = 0; r < 20; r++) begin
            do_reset();
            wdog_arm = ($urandom % 3 == 0);
            step(1'b1, 3'd0, 16'($urandom % 32));
            step(1'b1, 3'd2, 16'($urandom % 32));
            step(1'b1, 3'd6, sw(1, 2'b00, 1'($urandom), 2'($urandom), 2'($urandom),
                                1'($urandom), 4'($urandom % 3)));
            for (int i = 0; i < 400; i++) begin
                logic [15:0] d;
                logic [2:0]  a;
                ext_tick = 1'($urandom);
                dbg_halt = ($urandom % 8 == 0);
                irq_mask = 2'($urandom);
                a = 3'(($urandom % 4) * 2);
                if ($urandom % 10 == 0) begin
                    d = (a == 3'd6) ? (16'($urandom) | 16'h8000) : 16'($urandom % 40);
                    step(1'b1, a, d);
                end else begin
                    step(1'b0, a, 16'd0);
                end
            end
        end
        step(1'b0, 3'd0, 16'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule